// File: doc/BRIEF.md
# Negotiation Progress Monitor Register

This block sits beside a link auto-negotiation state machine and keeps a sticky record of the furthest point that machine has reached. The live state comes in as a four-bit code. The record is the same width: bit 3 is the completion flag and bits 2:0 are the progress code. The record only moves forward. It takes the live code only when that code is numerically larger than the value already stored. Reset, a disabled negotiation or a negotiation restart sends the record back to zero.

A management agent reads the record with a one-cycle read strobe. The value it sees is the one held before the strobe's clock edge. On that same edge the record reloads from the live state, so the next read reports progress measured from the state current at this read. A second sticky output latches high when the high-speed receive signal drops. It clears on a read, unless a new loss arrives in the read cycle. While the lower-speed mode is selected, the flag cannot set.

The read data, the read strobe and the control inputs are plain status and control pins with no handshake. Read data is valid in every cycle, so there is nothing to hold back.

Top module: `anprog_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, `prog_rec` becomes 0000 and `rx_lost` becomes 0 after that edge.
- R2: When `an_enable` is low at a clock edge, `prog_rec` becomes 0000 after the edge.
- R3: When `an_restart` is high at a clock edge, `prog_rec` becomes 0000 after the edge.
- R4: While enabled and not restarting, with no read, a valid `live_code` that is numerically greater than `prog_rec` is loaded into `prog_rec`. The codes are: 0 idle, 1 parallel detected, 2 parallel detection failure, 3 abilities matched, 4 acknowledge match failure, 5 acknowledged, 6 consistency match failure, 7 consistency matched, 8 completed (bit 3 is the completion flag).
- R5: Under the same conditions, a valid `live_code` that is equal to or lower than `prog_rec` leaves `prog_rec` unchanged.
- R6: In a cycle where `rd_strobe` is high, the outputs show the record held before the edge. After the edge, `prog_rec` equals that cycle's `live_code`, whether that code is higher or lower than the stored value.
- R7: A `live_code` above 8 (9 to 15) changes `prog_rec` neither by advance nor by read reload.
- R8: A clear from disable or restart wins over both a read reload and a forward update in the same cycle.
- R9: With `low_speed` low, a cycle with `rx_sig_ok` low sets `rx_lost` after the edge. The flag stays 1 until a read cycle clears it.
- R10: If a read and a loss (`rx_sig_ok` low with `low_speed` low) fall in the same cycle, `rx_lost` is 1 after the edge.
- R11: While `low_speed` is high, `rx_sig_ok` low does not set `rx_lost`. A read still clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| an_enable | input | 1 | Negotiation enabled; low clears the record |
| an_restart | input | 1 | Negotiation restart; high clears the record |
| live_code | input | 4 | Current negotiation state code |
| rd_strobe | input | 1 | One-cycle management read |
| rx_sig_ok | input | 1 | High-speed receive signal valid |
| low_speed | input | 1 | Lower-speed mode selected |
| prog_rec | output | 4 | Highest-progress record {done, code[2:0]} |
| rx_lost | output | 1 | Latched receive-signal-lost flag |

## Verification
The assertions assume that `rst` is held for at least one edge before any other stimulus matters. They also treat `live_code` as an arbitrary four-bit value, so out-of-range codes are legal stimulus and not an assumption. They assume nothing about how the state machine orders its states. For this reason the stimulus walks the live code randomly, with backward jumps, repeats and codes 9 to 15, so that the forward-only rule and the read reload are exercised against a reference maximum. The control inputs change only on the falling clock edge, so every property sees stable values at the rising edge.

// File: rtl/anprog_pkg.sv
package anprog_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_TOP = 8;

  typedef enum logic [CODE_W-1:0] {
    NEG_IDLE       = 4'd0,
    NEG_PAR_SEEN   = 4'd1,
    NEG_PAR_FAIL   = 4'd2,
    NEG_ABIL_OK    = 4'd3,
    NEG_ACK_FAIL   = 4'd4,
    NEG_ACK_OK     = 4'd5,
    NEG_CONS_FAIL  = 4'd6,
    NEG_CONS_OK    = 4'd7,
    NEG_DONE       = 4'd8
  } neg_code_e;
endpackage

// File: rtl/anprog_record.sv
module anprog_record #(
  parameter int W   = anprog_pkg::CODE_W,
  parameter int TOP = anprog_pkg::CODE_TOP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         rd,
  input  logic [W-1:0] live,
  output logic [W-1:0] rec
);
  localparam logic [W-1:0] TOP_V = W'(TOP);

  logic live_ok;
  logic advance;

  assign live_ok = (live <= TOP_V);
  assign advance = live_ok && (live > rec);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rec <= '0;
    end else if (rd) begin
      if (live_ok) rec <= live;
    end else if (advance) begin
      rec <= live;
    end
  end
endmodule

// File: rtl/anprog_loss_latch.sv
module anprog_loss_latch (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic sig_ok,
  input  logic rd,
  output logic lost
);
  logic loss_evt;
  assign loss_evt = armed && !sig_ok;

  always_ff @(posedge clk) begin
    if (rst)           lost <= 1'b0;
    else if (loss_evt) lost <= 1'b1;
    else if (rd)       lost <= 1'b0;
  end
endmodule

// File: rtl/anprog_monitor.sv
module anprog_monitor #(
  parameter int CODE_W   = anprog_pkg::CODE_W,
  parameter int CODE_TOP = anprog_pkg::CODE_TOP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              an_enable,
  input  logic              an_restart,
  input  logic [CODE_W-1:0] live_code,
  input  logic              rd_strobe,
  input  logic              rx_sig_ok,
  input  logic              low_speed,
  output logic [CODE_W-1:0] prog_rec,
  output logic              rx_lost
);
  logic rec_clr;
  assign rec_clr = !an_enable || an_restart;

  anprog_record #(.W(CODE_W), .TOP(CODE_TOP)) u_rec (
    .clk  (clk),
    .rst  (rst),
    .clr  (rec_clr),
    .rd   (rd_strobe),
    .live (live_code),
    .rec  (prog_rec)
  );

  anprog_loss_latch u_loss (
    .clk    (clk),
    .rst    (rst),
    .armed  (!low_speed),
    .sig_ok (rx_sig_ok),
    .rd     (rd_strobe),
    .lost   (rx_lost)
  );
endmodule

// File: rtl/anprog_monitor_chk.sv
module anprog_monitor_chk #(
  parameter int CODE_W   = 4,
  parameter int CODE_TOP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              an_enable,
  input logic              an_restart,
  input logic [CODE_W-1:0] live_code,
  input logic              rd_strobe,
  input logic              rx_sig_ok,
  input logic              low_speed,
  input logic [CODE_W-1:0] prog_rec,
  input logic              rx_lost
);
  localparam logic [CODE_W-1:0] TOP_V = CODE_W'(CODE_TOP);

  logic run;
  assign run = an_enable && !an_restart;

  assert_clear_R2_R3_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> prog_rec == '0);

  assert_forward_only_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !rd_strobe) |=> prog_rec >= $past(prog_rec));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !rd_strobe && live_code <= TOP_V && live_code > prog_rec)
      |=> prog_rec == $past(live_code));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (run && rd_strobe && live_code <= TOP_V) |=> prog_rec == $past(live_code));

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (rst)
    (run && live_code > TOP_V) |=> $stable(prog_rec));

  assert_loss_sets_R9_R10: assert property (@(posedge clk) disable iff (rst)
    (!low_speed && !rx_sig_ok) |=> rx_lost);

  assert_low_speed_R11: assert property (@(posedge clk) disable iff (rst)
    (low_speed && !rx_lost) |=> !rx_lost);

  assert_rec_range_R4: assert property (@(posedge clk) disable iff (rst)
    prog_rec <= TOP_V);
endmodule

bind anprog_monitor anprog_monitor_chk #(.CODE_W(CODE_W), .CODE_TOP(CODE_TOP)) u_chk (
  .clk(clk), .rst(rst), .an_enable(an_enable), .an_restart(an_restart),
  .live_code(live_code), .rd_strobe(rd_strobe), .rx_sig_ok(rx_sig_ok),
  .low_speed(low_speed), .prog_rec(prog_rec), .rx_lost(rx_lost)
);

// File: tb/tb_anprog_monitor.sv
module tb_anprog_monitor;
  logic       clk = 1'b0;
  logic       rst, an_enable, an_restart, rd_strobe, rx_sig_ok, low_speed;
  logic [3:0] live_code;
  logic [3:0] prog_rec;
  logic       rx_lost;

  int vectors = 0;
  int errors  = 0;
  logic [3:0] m_rec  = 4'd0;
  logic       m_lost = 1'b0;

  always #5 clk = ~clk;

  anprog_monitor dut (
    .clk(clk), .rst(rst), .an_enable(an_enable), .an_restart(an_restart),
    .live_code(live_code), .rd_strobe(rd_strobe), .rx_sig_ok(rx_sig_ok),
    .low_speed(low_speed), .prog_rec(prog_rec), .rx_lost(rx_lost)
  );

  task automatic check(input string req, input logic [3:0] rec_exp, input logic lost_exp);
    vectors++;
    if (prog_rec !== rec_exp || rx_lost !== lost_exp) begin
      errors++;
      $display("FAIL %s: rec=%0d lost=%0b expected rec=%0d lost=%0b",
               req, prog_rec, rx_lost, rec_exp, lost_exp);
    end
  endtask

  // One clock with the given inputs; the reference is built from the requirements.
  task automatic step(input logic r, input logic en, input logic rs, input logic [3:0] live,
                      input logic rd, input logic ok, input logic low, input string req);
    @(negedge clk);
    rst = r; an_enable = en; an_restart = rs; live_code = live;
    rd_strobe = rd; rx_sig_ok = ok; low_speed = low;
    #1;
    if (rd && !r) check({req, " R6 pre-edge read"}, m_rec, m_lost);
    if (r) begin
      m_rec = 4'd0; m_lost = 1'b0;
    end else begin
      if (!en || rs)                  m_rec = 4'd0;
      else if (live <= 4'd8 && rd)    m_rec = live;
      else if (live <= 4'd8 && live > m_rec) m_rec = live;
      if (!low && !ok)                m_lost = 1'b1;
      else if (rd)                    m_lost = 1'b0;
    end
    @(posedge clk); #1;
    check(req, m_rec, m_lost);
  endtask

  task automatic run_step(input logic [3:0] live, input string req);
    step(1'b0, 1'b1, 1'b0, live, 1'b0, 1'b1, 1'b0, req);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b1, 1'b0, "R1");
  endtask

  task automatic t_forward;
    run_step(4'd1, "R4"); run_step(4'd3, "R4"); run_step(4'd2, "R5");
    run_step(4'd3, "R5"); run_step(4'd7, "R4"); run_step(4'd0, "R5");
    run_step(4'd8, "R4"); run_step(4'd6, "R5");
  endtask

  task automatic t_read_reload;
    step(1'b0, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0, "R6 reload lower");
    run_step(4'd1, "R5");
    run_step(4'd4, "R4");
    step(1'b0, 1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 1'b0, "R6 reload higher");
  endtask

  task automatic t_invalid;
    run_step(4'd9,  "R7");
    run_step(4'd15, "R7");
    step(1'b0, 1'b1, 1'b0, 4'd12, 1'b1, 1'b1, 1'b0, "R7 read with bad code");
  endtask

  task automatic t_clear;
    run_step(4'd7, "R4");
    step(1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 1'b0, "R2");
    run_step(4'd5, "R4");
    step(1'b0, 1'b1, 1'b1, 4'd8, 1'b0, 1'b1, 1'b0, "R3");
    run_step(4'd3, "R4");
    step(1'b0, 1'b1, 1'b1, 4'd6, 1'b1, 1'b1, 1'b0, "R8 restart+read");
    run_step(4'd4, "R4");
    step(1'b0, 1'b0, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0, "R8 disable+read");
  endtask

  task automatic t_loss;
    step(1'b0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, "R9 set");
    run_step(4'd1, "R9 hold");
    run_step(4'd2, "R9 hold");
    step(1'b0, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0, "R9 read clears");
    step(1'b0, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, "R9 set again");
    step(1'b0, 1'b1, 1'b0, 4'd2, 1'b1, 1'b0, 1'b0, "R10 read+loss");
    step(1'b0, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0, "R10 later read clears");
  endtask

  task automatic t_low_speed;
    step(1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b1, "R11 no set");
    step(1'b0, 1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1, "R11 read no set");
    step(1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, "R9 set high speed");
    step(1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b1, "R11 holds");
    step(1'b0, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b1, "R11 read clears");
  endtask

  task automatic t_random_walk;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] lv;
      logic rd, ok, low, en, rs;
      lv  = ($urandom_range(0, 9) == 0) ? 4'(9 + $urandom_range(0, 6)) : 4'($urandom_range(0, 8));
      rd  = ($urandom_range(0, 7) == 0);
      ok  = ($urandom_range(0, 5) != 0);
      low = ($urandom_range(0, 4) == 0);
      en  = ($urandom_range(0, 30) != 0);
      rs  = ($urandom_range(0, 40) == 0);
      step(1'b0, en, rs, lv, rd, ok, low, "R4 R5 R6 R9 random walk");
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; an_enable = 1'b1; an_restart = 1'b0; live_code = 4'd0;
    rd_strobe = 1'b0; rx_sig_ok = 1'b1; low_speed = 1'b0;
    t_reset();
    t_forward();
    t_read_reload();
    t_invalid();
    t_clear();
    t_loss();
    t_low_speed();
    t_random_walk();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule